// File: doc/BRIEF.md
# Serial Addressed DAC Code Register Bank

This block is the digital control side of a multi-channel 10-bit digital-to-analog converter. A host drives three serial wires: a shift clock, a data line and a load strobe. It also drives an active-low reset. The block samples the data line on each rising edge of the shift clock, most significant bit first. It keeps the last 14 bits shifted in. The upper 4 of these bits name a channel and the lower 10 bits are a code. When the load strobe goes high, the code is copied into that channel's output register. All channel registers are presented in parallel so that a converter stage can use them.

The three serial wires are asynchronous to the system clock. Each wire passes through a two-flop synchroniser, and edges are detected in the system clock domain. The load strobe is level-sensitive, so shift clock edges that arrive while it is high are discarded. Each high level of the load strobe writes at most once. Reset is asserted asynchronously and released synchronously. Reset clears both the shift register and every channel register to the zero code, which is the code for the lower reference.

Top module: `dac_serial_bank`

## Requirements
- R1: A frame is 14 bits, sampled on rising shift-clock edges, most significant bit first. After the 14th bit, register bit 13..10 holds the channel address and bit 9..0 holds the code.
- R2: The rising edge of the load level writes the addressed channel once. Keeping load high for longer causes no further write and changes no output.
- R3: Address k with 1 ≤ k ≤ NUM_CH writes channel k. Channel k appears on `code_o[(k-1)*10 +: 10]`, and no other channel changes.
- R4: Address 0 and addresses NUM_CH+1..15 change no channel register.
- R5: A rising shift-clock edge seen while load is high, including one in the same system cycle as the load edge, shifts nothing.
- R6: When `rst_n` goes low, every channel output becomes 0 at once and the shift register clears. A load that follows reset with no bits shifted therefore carries address 0 and writes nothing.
- R7: A load after fewer or more than 14 bits uses whatever the low 14 bits of the shift register hold at that moment.
- R8: A load edge driven just after a falling system-clock edge first shows on the outputs after the third following rising system-clock edge. The outputs still hold the old value after the second.
- R9: NUM_CH sets the number of channel registers. Builds with 4 and 6 channels are supported, and the output width is NUM_CH*10.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, faster than the shift clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sclk_i | input | 1 | Serial shift clock, asynchronous |
| sdat_i | input | 1 | Serial data, sampled on shift-clock rise |
| sload_i | input | 1 | Level-sensitive load strobe |
| code_o | output | NUM_CH*10 | Channel codes, channel 1 in the lowest 10 bits |

## Verification
A shift-clock rise and a load rise can land in the same system cycle. The shift must then be suppressed, and the load must copy the frame as it stood before that edge. The bench provokes this by raising the shift clock and the load strobe in the same instant. It then reads the written channel to judge whether the extra bit entered the frame. It also violates the protocol on purpose by toggling the shift clock during a long load. A partial-frame load that follows exposes whether those edges were shifted.

// File: rtl/dac_bank_pkg.sv
package dac_bank_pkg;
  localparam int unsigned CODE_W  = 10;
  localparam int unsigned ADDR_W  = 4;
  localparam int unsigned FRAME_W = ADDR_W + CODE_W;

  // Positions of the serial wires within the synchroniser vector
  localparam int unsigned PIN_SCLK = 0;
  localparam int unsigned PIN_SDAT = 1;
  localparam int unsigned PIN_LOAD = 2;
  localparam int unsigned PIN_N    = 3;

  typedef struct packed {
    logic [ADDR_W-1:0] addr;
    logic [CODE_W-1:0] code;
  } frame_t;
endpackage

// File: rtl/dac_rst_sync.sv
module dac_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sys_n
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign rst_sys_n = chain_q[STAGES-1];
endmodule

// File: rtl/dac_in_sync.sv
module dac_in_sync #(
  parameter int unsigned W = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] raw_i,
  output logic [W-1:0] lvl_o,
  output logic [W-1:0] rise_o
);
  logic [W-1:0] meta_q, meta_d;
  logic [W-1:0] lvl_q,  lvl_d;
  logic [W-1:0] prev_q, prev_d;

  always_comb begin
    meta_d = raw_i;
    lvl_d  = meta_q;
    prev_d = lvl_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '0;
      lvl_q  <= '0;
      prev_q <= '0;
    end else begin
      meta_q <= meta_d;
      lvl_q  <= lvl_d;
      prev_q <= prev_d;
    end
  end

  for (genvar b = 0; b < W; b++) begin : g_edge
    assign lvl_o[b]  = lvl_q[b];
    assign rise_o[b] = lvl_q[b] & ~prev_q[b];
  end
endmodule

// File: rtl/dac_frame_shift.sv
module dac_frame_shift #(
  parameter int unsigned FRAME_W = dac_bank_pkg::FRAME_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               shift_en,
  input  logic               bit_i,
  output logic [FRAME_W-1:0] frame_o
);
  logic [FRAME_W-1:0] frame_q, frame_d;

  always_comb begin
    frame_d = frame_q;
    if (shift_en) frame_d = {frame_q[FRAME_W-2:0], bit_i};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        frame_q <= '0;
    else if (shift_en) frame_q <= frame_d;
  end

  assign frame_o = frame_q;
endmodule

// File: rtl/dac_chan_latches.sv
module dac_chan_latches #(
  parameter int unsigned NUM_CH = 4,
  parameter int unsigned ADDR_W = dac_bank_pkg::ADDR_W,
  parameter int unsigned CODE_W = dac_bank_pkg::CODE_W,
  localparam int unsigned OUT_W = NUM_CH * CODE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [CODE_W-1:0] wr_code,
  output logic [OUT_W-1:0]  codes_o
);
  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    logic              hit;
    logic [CODE_W-1:0] code_q, code_d;

    always_comb begin
      hit    = wr_en && (wr_addr == ADDR_W'(c + 1));
      code_d = hit ? wr_code : code_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   code_q <= '0;
      else if (hit) code_q <= code_d;
    end

    assign codes_o[c*CODE_W +: CODE_W] = code_q;
  end
endmodule

// File: rtl/dac_serial_bank.sv
module dac_serial_bank #(
  parameter int unsigned NUM_CH = 4,
  localparam int unsigned CODE_W  = dac_bank_pkg::CODE_W,
  localparam int unsigned ADDR_W  = dac_bank_pkg::ADDR_W,
  localparam int unsigned FRAME_W = dac_bank_pkg::FRAME_W,
  localparam int unsigned OUT_W   = NUM_CH * CODE_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sclk_i,
  input  logic             sdat_i,
  input  logic             sload_i,
  output logic [OUT_W-1:0] code_o
);
  import dac_bank_pkg::*;

  logic               rst_sys_n;
  logic [PIN_N-1:0]   pins_raw, pins_lvl, pins_rise;
  logic               ld_lvl, ld_rise, sclk_rise, shift_en;
  logic [FRAME_W-1:0] frame_q;
  frame_t             frame_s;

  dac_rst_sync #(.STAGES(2)) i_rst_sync (
    .clk       (clk),
    .rst_n     (rst_n),
    .rst_sys_n (rst_sys_n)
  );

  always_comb begin
    pins_raw           = '0;
    pins_raw[PIN_SCLK] = sclk_i;
    pins_raw[PIN_SDAT] = sdat_i;
    pins_raw[PIN_LOAD] = sload_i;
  end

  dac_in_sync #(.W(PIN_N)) i_in_sync (
    .clk    (clk),
    .rst_n  (rst_sys_n),
    .raw_i  (pins_raw),
    .lvl_o  (pins_lvl),
    .rise_o (pins_rise)
  );

  always_comb begin
    ld_lvl    = pins_lvl[PIN_LOAD];
    ld_rise   = pins_rise[PIN_LOAD];
    sclk_rise = pins_rise[PIN_SCLK];
    shift_en  = sclk_rise && !ld_lvl;
  end

  dac_frame_shift #(.FRAME_W(FRAME_W)) i_shift (
    .clk      (clk),
    .rst_n    (rst_sys_n),
    .shift_en (shift_en),
    .bit_i    (pins_lvl[PIN_SDAT]),
    .frame_o  (frame_q)
  );

  assign frame_s = frame_t'(frame_q);

  dac_chan_latches #(
    .NUM_CH (NUM_CH),
    .ADDR_W (ADDR_W),
    .CODE_W (CODE_W)
  ) i_latches (
    .clk     (clk),
    .rst_n   (rst_sys_n),
    .wr_en   (ld_rise),
    .wr_addr (frame_s.addr),
    .wr_code (frame_s.code),
    .codes_o (code_o)
  );
endmodule

// File: rtl/dac_serial_bank_chk.sv
module dac_serial_bank_chk #(
  parameter int unsigned NUM_CH = 4,
  localparam int unsigned CODE_W  = dac_bank_pkg::CODE_W,
  localparam int unsigned ADDR_W  = dac_bank_pkg::ADDR_W,
  localparam int unsigned FRAME_W = dac_bank_pkg::FRAME_W,
  localparam int unsigned OUT_W   = NUM_CH * CODE_W
) (
  input logic               clk,
  input logic               rst_n,
  input logic               rst_sys_n,
  input logic               ld_lvl,
  input logic               ld_rise,
  input logic [FRAME_W-1:0] frame,
  input logic [OUT_W-1:0]   codes
);
  logic [ADDR_W-1:0] addr_f;
  logic              addr_bad;
  assign addr_f   = frame[FRAME_W-1 -: ADDR_W];
  assign addr_bad = (addr_f == '0) || (addr_f > ADDR_W'(NUM_CH));

  always @(posedge clk) begin
    if (!rst_n) begin
      AST_RESET_ZERO: assert (codes == '0); // R6
    end
  end

  AST_NO_SHIFT_IN_LOAD: assert property (@(posedge clk) disable iff (!rst_sys_n)
    ld_lvl |=> $stable(frame)); // R5

  AST_WRITE_ONLY_ON_LOAD: assert property (@(posedge clk) disable iff (!rst_sys_n)
    !$stable(codes) |-> $past(ld_rise)); // R2

  AST_BAD_ADDR_IGNORED: assert property (@(posedge clk) disable iff (!rst_sys_n)
    (ld_rise && addr_bad) |=> $stable(codes)); // R4

  for (genvar c = 0; c < NUM_CH; c++) begin : g_wr
    AST_CHANNEL_WRITE: assert property (@(posedge clk) disable iff (!rst_sys_n)
      (ld_rise && addr_f == ADDR_W'(c + 1)) |=>
        codes[c*CODE_W +: CODE_W] == $past(frame[CODE_W-1:0])); // R3
  end
endmodule

bind dac_serial_bank dac_serial_bank_chk #(.NUM_CH(NUM_CH)) i_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .rst_sys_n (rst_sys_n),
  .ld_lvl    (ld_lvl),
  .ld_rise   (ld_rise),
  .frame     (frame_q),
  .codes     (code_o)
);

// File: tb/test_dac_serial_bank.sv
module test_dac_serial_bank;
  localparam int NCH = 6;

  logic clk = 1'b0;
  logic rst_n, sclk, sdat, sload;
  logic [NCH*10-1:0] code_o;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;
  bit cmp_en = 1'b0;

  int exp_code [NCH];
  int model_sr = 0;

  always #5 clk = ~clk;

  dac_serial_bank #(.NUM_CH(NCH)) i_dac_serial_bank (
    .clk (clk), .rst_n (rst_n), .sclk_i (sclk), .sdat_i (sdat),
    .sload_i (sload), .code_o (code_o)
  );

  function automatic int chan(int i);
    return int'(code_o[i*10 +: 10]);
  endfunction

  task automatic check_val(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic check_all(string tag, int e [NCH]);
    for (int i = 0; i < NCH; i++) check_val(tag, chan(i), e[i]);
  endtask

  // Per-clock comparison against the reference model in quiet periods
  always @(negedge clk) begin
    if (cmp_en && !done) check_all("R3 per-clock", exp_code);
  end

  task automatic send_bit(bit b);
    @(negedge clk); sdat = b;
    repeat (2) @(negedge clk);
    sclk = 1'b1;
    if (!sload) model_sr = ((model_sr << 1) | int'(b)) & 'h3fff;
    else $display("note: protocol violation provoked (shift clock while load high)");
    repeat (6) @(negedge clk);
    sclk = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  task automatic send_frame(int addr, int code);
    int f = ((addr & 'hf) << 10) | (code & 'h3ff);
    for (int i = 13; i >= 0; i--) send_bit(f[i]);
  endtask

  task automatic model_load();
    int a = model_sr >> 10;
    if (a >= 1 && a <= NCH) exp_code[a-1] = model_sr & 'h3ff;
  endtask

  // Load with latency check; R8 old value after two edges, new after three
  task automatic do_load(string tag, int hold);
    int old_v [NCH];
    cmp_en = 1'b0;
    old_v = exp_code;
    @(negedge clk); sload = 1'b1;
    model_load();
    repeat (2) @(negedge clk);
    check_all({tag, " R8 before"}, old_v);
    @(negedge clk);
    check_all({tag, " R8 after"}, exp_code);
    repeat (hold) @(negedge clk);
    check_all({tag, " R2 held"}, exp_code);
    sload = 1'b0;
    repeat (4) @(negedge clk);
    cmp_en = 1'b1;
  endtask

  task automatic do_reset();
    cmp_en = 1'b0;
    @(negedge clk); #2 rst_n = 1'b0;
    #1;
    for (int i = 0; i < NCH; i++) exp_code[i] = 0;
    model_sr = 0;
    check_all("R6 async clear", exp_code);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    cmp_en = 1'b1;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    int v;
    rst_n = 1'b1; sclk = 1'b0; sdat = 1'b0; sload = 1'b0;
    for (int i = 0; i < NCH; i++) exp_code[i] = 0;
    #1 rst_n = 1'b0;
    #1;
    check_all("R6 reset state", exp_code);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    cmp_en = 1'b1;

    // R1 R3 R9: every channel, distinct codes, MSB ordering
    for (int c = 1; c <= NCH; c++) begin
      send_frame(c, (c * 97 + 'h201) & 'h3ff);
      do_load("R3 write", 2);
    end
    send_frame(2, 'h3ff); do_load("R1 all ones", 2);
    send_frame(5, 'h001); do_load("R1 lsb only", 2);
    send_frame(5, 'h200); do_load("R1 msb only", 2);

    // R4: invalid addresses
    send_frame(0, 'h155);  do_load("R4 addr 0", 2);
    send_frame(NCH + 1, 'h2aa); do_load("R4 addr N+1", 2);
    send_frame(15, 'h3c3); do_load("R4 addr 15", 2);

    // R2: long load level, single write
    send_frame(3, 'h0f0); do_load("R2 long level", 40);
    check_val("R2 ch3", chan(2), 'h0f0);

    // R5 R7: shift clock during load, then a partial frame
    send_frame(1, 'h0c7);
    cmp_en = 1'b0;
    @(negedge clk); sload = 1'b1; model_load();
    repeat (6) @(negedge clk);
    for (int k = 0; k < 4; k++) send_bit(1'b1);
    sload = 1'b0;
    repeat (4) @(negedge clk);
    cmp_en = 1'b1;
    check_val("R5 ch1 after violation", chan(0), 'h0c7);
    send_bit(1'b1); send_bit(1'b0);
    do_load("R7 partial frame", 2);
    check_val("R7 ch4", chan(3), 'h31e);

    // R5: shift clock rise and load rise in the same instant
    send_frame(6, 'h0a5);
    cmp_en = 1'b0;
    @(negedge clk); sdat = 1'b1;
    @(negedge clk); sclk = 1'b1; sload = 1'b1;
    model_load();
    repeat (8) @(negedge clk);
    sclk = 1'b0;
    repeat (4) @(negedge clk);
    check_all("R5 same cycle", exp_code);
    check_val("R5 ch6", chan(5), 'h0a5);
    sload = 1'b0;
    repeat (4) @(negedge clk);
    cmp_en = 1'b1;

    // R6: mid-run reset, then a load with an empty register
    do_reset();
    do_load("R6 empty load", 2);
    v = 'h2d2;
    send_frame(4, v); do_load("R6 after reset", 2);
    check_val("R6 ch4 rewrite", chan(3), v);

    repeat (5) @(negedge clk);
    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule